// File: doc/BRIEF.md
# Serial Port Status Flags with Two-Step Clear

This block is the register front end of an asynchronous serial port. It keeps nine status flags and one received-data register. The transmitter and the receiver raise the flags with single-cycle set pulses. Software lowers a flag in two steps. First it reads the status half-word while the flag is set, which arms the flag. Then it accesses the data half-word: a read lowers armed receive flags, and a write lowers the armed transmit-complete flag. Each flag has its own arm bit, so a flag that the hardware raises between the two steps stays set until software runs a new pair of steps.

The bus port is a plain register port. It has an address compare, read and write strobes and four byte enables, which allow 8-, 16- and 32-bit accesses. The 32-bit word at the matching address holds the status half-word in bits 31:16 and the data half-word in bits 15:0. Two streams cross the block. The first is received bytes in on `rx_valid`/`rx_data`. It has no ready signal, because a receiver cannot be stalled: a new byte overwrites the register, and overruns are reported on the overrun set pulse. The second is transmit bytes out on `tx_valid`/`tx_data`. This is a one-cycle strobe with no back-pressure, and the transmitter must take the byte in that cycle. Flow toward the transmitter is paced by software polling the transmit-empty flag.

Top module: `uart_status_front`

## Requirements
- R1: After reset the status half-word reads 0x0180 (transmit-empty and transmit-complete set, all others clear), and the data half-word reads 0.
- R2: Status half-word layout: bit 8 transmit-empty, bit 7 transmit-complete, bit 6 receive-full, bit 5 receiver-active, bit 4 line-idle, bit 3 overrun, bit 2 noise, bit 1 framing, bit 0 parity. Bits 15:9 read 0. Byte enable k selects read data bits 8k+7:8k. Bits 31:16 are status and bits 15:0 are data.
- R3: A receive flag (bits 6:0) is cleared by a data read with `bus_be[0]` set, but only if a status read saw the flag set beforehand. A data read made without that arming read leaves the flag set.
- R4: Transmit-complete is cleared only by a data write with `bus_be[0]` set after an arming status read. A data read leaves it set, and a data write leaves the receive flags set.
- R5: Transmit-empty is never changed by the bus. It is set by `tx_empty_set`, cleared by `tx_empty_clr`, and the set pulse wins when both arrive in the same cycle.
- R6: A status read through either status byte lane (`bus_be[3]` or `bus_be[2]`) arms every flag that is set in the whole half-word.
- R7: A flag raised after the arming read survives the following data access. Clearing it needs a new status read and a new data access.
- R8: Writes to the status lanes change nothing and do not arm any flag.
- R9: A 32-bit read (`bus_be` = 4'hF) returns status and data together. It clears the receive flags that were set at the time of that read and leaves bits 8 and 7 unchanged.
- R10: A set pulse that arrives in the same cycle as a clearing access keeps its flag set and leaves that flag unarmed.
- R11: `rx_valid` loads `rx_data` into the data register and sets receive-full. A data read returns the byte in bits 7:0.
- R12: A data write with `bus_be[0]` set pulses `tx_valid` for one cycle, one clock later, with `tx_data` equal to `bus_wdata[7:0]`. A write on `bus_be[1]` alone gives no pulse and clears nothing.
- R13: An access at an address other than `BASE` returns 0 and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Word address, compared with BASE |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 4 | Byte enables; lane 3/2 status, lane 1/0 data |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero outside a matching read |
| rx_valid | input | 1 | Received byte valid; sets receive-full |
| rx_data | input | DATA_W | Received byte |
| rx_evt_set | input | 6 | Set pulses for status bits 5:0 |
| tx_empty_set | input | 1 | Transmitter sets transmit-empty |
| tx_empty_clr | input | 1 | Transmitter clears transmit-empty |
| tx_done_set | input | 1 | Transmitter sets transmit-complete |
| tx_valid | output | 1 | One-cycle strobe for a written transmit byte |
| tx_data | output | DATA_W | Transmit byte |

## Verification
The bench builds the block with ADDR_W = 4, BASE = 6 and DATA_W = 8. With these values the bench can sweep all 128 combinations of receive flags through the combined 32-bit read, and reach every receive flag from both status lanes. Each receive flag is also put through the set-after-arm race and the same-cycle set-versus-clear race. The small address space allows a single flipped address bit to test the no-match case.

// File: rtl/uart_sfr_pkg.sv
package uart_sfr_pkg;
  localparam int FLAG_N = 9;
  localparam int F_RDRF = 6;
  localparam int F_TC   = 7;
  localparam int F_TDRE = 8;

  typedef enum logic [1:0] {
    CLR_NONE,
    CLR_ON_DREAD,
    CLR_ON_DWRITE
  } clr_kind_e;

  function automatic clr_kind_e kind_of(int idx);
    if (idx == F_TDRE) return CLR_NONE;
    if (idx == F_TC) return CLR_ON_DWRITE;
    return CLR_ON_DREAD;
  endfunction

  function automatic logic reset_of(int idx);
    return (idx == F_TDRE) || (idx == F_TC);
  endfunction
endpackage

// File: rtl/sfr_bus_decode.sv
module sfr_bus_decode #(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [3:0]        bus_be,
  output logic              rd_hit,
  output logic              stat_rd,
  output logic              dread,
  output logic              dwrite
);
  logic hit;
  logic rd_only;
  logic wr_only;

  assign hit     = (bus_addr == BASE);
  assign rd_only = bus_rd & ~bus_wr;
  assign wr_only = bus_wr & ~bus_rd;
  assign rd_hit  = hit & rd_only;
  // either status lane counts as a status read
  assign stat_rd = rd_hit & (bus_be[3] | bus_be[2]);
  // only the low data lane takes part in clearing
  assign dread   = rd_hit & bus_be[0];
  assign dwrite  = hit & wr_only & bus_be[0];
endmodule

// File: rtl/sfr_flag_cell.sv
module sfr_flag_cell #(
  parameter uart_sfr_pkg::clr_kind_e KIND = uart_sfr_pkg::CLR_ON_DREAD,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic hw_clr,
  input  logic stat_rd,
  input  logic dread,
  input  logic dwrite,
  output logic flag_q
);
  logic arm_q;
  logic bus_acc;
  logic arm_eff;
  logic bus_clear;

  generate
    if (KIND == uart_sfr_pkg::CLR_ON_DREAD) begin : g_rd
      assign bus_acc = dread;
    end else if (KIND == uart_sfr_pkg::CLR_ON_DWRITE) begin : g_wr
      assign bus_acc = dwrite;
    end else begin : g_none
      assign bus_acc = 1'b0;
    end
  endgenerate

  // a status read in the same cycle as the data access also counts as arming
  assign arm_eff   = arm_q | (stat_rd & flag_q);
  assign bus_clear = bus_acc & arm_eff & ~hw_set;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= RST_VAL;
      arm_q  <= 1'b0;
    end else begin
      if (hw_set)                     flag_q <= 1'b1;
      else if (bus_clear || hw_clr)   flag_q <= 1'b0;

      if (hw_set || bus_clear || hw_clr) arm_q <= 1'b0;
      else if (stat_rd)                  arm_q <= flag_q;
    end
  end

  // R10: a set pulse always leaves the flag high
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set |=> flag_q);

  // R7: an armed flag is always a set flag
  a_r7_arm_within_flag: assert property (@(posedge clk) disable iff (!rst_n)
    arm_q |-> flag_q);

  // R3 / R5: a flag falls only by hardware clear or an armed matching access
  a_r3_fall_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flag_q) && !flag_q) |->
      ($past(hw_clr) || ($past(bus_acc) && ($past(arm_q) || $past(stat_rd)))));
endmodule

// File: rtl/sfr_data_path.sv
module sfr_data_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              dwrite,
  input  logic [DATA_W-1:0] wr_byte,
  output logic [DATA_W-1:0] data_q,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q   <= '0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      if (rx_valid) data_q <= rx_data;
      tx_valid <= dwrite;
      if (dwrite) tx_data <= wr_byte;
    end
  end
endmodule

// File: rtl/uart_status_front.sv
module uart_status_front #(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] BASE = 4'h6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [5:0]        rx_evt_set,
  input  logic              tx_empty_set,
  input  logic              tx_empty_clr,
  input  logic              tx_done_set,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data
);
  import uart_sfr_pkg::*;

  localparam int PAD_W = 16 - DATA_W;

  logic              rd_hit;
  logic              stat_rd;
  logic              dread;
  logic              dwrite;
  logic [FLAG_N-1:0] flags;
  logic [FLAG_N-1:0] set_vec;
  logic [FLAG_N-1:0] clr_vec;
  logic [DATA_W-1:0] data_q;
  logic [31:0]       word;
  logic              unused_wdata;

  assign unused_wdata = ^bus_wdata[31:DATA_W];

  sfr_bus_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_be(bus_be),
    .rd_hit(rd_hit), .stat_rd(stat_rd), .dread(dread), .dwrite(dwrite)
  );

  assign set_vec = {tx_empty_set, tx_done_set, rx_valid, rx_evt_set};
  assign clr_vec = {tx_empty_clr, {(FLAG_N-1){1'b0}}};

  generate
    for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
      sfr_flag_cell #(.KIND(kind_of(i)), .RST_VAL(reset_of(i))) u_cell (
        .clk(clk), .rst_n(rst_n),
        .hw_set(set_vec[i]), .hw_clr(clr_vec[i]),
        .stat_rd(stat_rd), .dread(dread), .dwrite(dwrite),
        .flag_q(flags[i])
      );
    end
  endgenerate

  sfr_data_path #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .dwrite(dwrite), .wr_byte(bus_wdata[DATA_W-1:0]),
    .data_q(data_q), .tx_valid(tx_valid), .tx_data(tx_data)
  );

  assign word = {{(16-FLAG_N){1'b0}}, flags, {PAD_W{1'b0}}, data_q};

  generate
    for (genvar k = 0; k < 4; k++) begin : g_lane
      assign bus_rdata[8*k +: 8] = (rd_hit && bus_be[k]) ? word[8*k +: 8] : 8'h00;
    end
  endgenerate

  // R8: a write without the low data lane leaves every flag as it was
  a_r8_status_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_rd && bus_addr == BASE && !bus_be[0] &&
     set_vec == '0 && !tx_empty_clr) |=> $stable(flags));

  // R12: the transmit strobe follows a matching low-lane write
  a_r12_tx_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(bus_wr && !bus_rd && bus_addr == BASE && bus_be[0]));

  // R13: no matching read, no read data
  a_r13_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && !bus_wr && bus_addr == BASE) |-> (bus_rdata == 32'h0));
endmodule

// File: tb/sim_uart_status_front.sv
module sim_uart_status_front;
  localparam int P = 10;
  localparam int AW = 4;
  localparam logic [AW-1:0] BASE = 4'h6;

  logic clk = 1'b0;
  always #(P/2) clk = ~clk;

  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = BASE;
  logic          bus_rd = 1'b0, bus_wr = 1'b0;
  logic [3:0]    bus_be = 4'h0;
  logic [31:0]   bus_wdata = 32'h0;
  logic [31:0]   bus_rdata;
  logic          rx_valid = 1'b0;
  logic [7:0]    rx_data = 8'h0;
  logic [5:0]    rx_evt_set = 6'h0;
  logic          tx_empty_set = 1'b0, tx_empty_clr = 1'b0, tx_done_set = 1'b0;
  logic          tx_valid;
  logic [7:0]    tx_data;

  uart_status_front #(.ADDR_W(AW), .BASE(BASE), .DATA_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_evt_set(rx_evt_set),
    .tx_empty_set(tx_empty_set), .tx_empty_clr(tx_empty_clr), .tx_done_set(tx_done_set),
    .tx_valid(tx_valid), .tx_data(tx_data)
  );

  int n_chk = 0;
  int n_err = 0;
  logic [7:0]  exp_d = 8'h00;
  logic [31:0] r;
  logic [15:0] s;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(output logic [31:0] rv);
    #(P/4) rv = bus_rdata;
    @(posedge clk);
    #1;
    bus_rd = 1'b0; bus_wr = 1'b0; bus_be = 4'h0; bus_addr = BASE; bus_wdata = 32'h0;
    rx_valid = 1'b0; rx_evt_set = 6'h0;
    tx_empty_set = 1'b0; tx_empty_clr = 1'b0; tx_done_set = 1'b0;
  endtask

  task automatic acc(input logic rd, input logic wr, input logic [3:0] be,
                     input logic [31:0] wd, input logic [AW-1:0] ad,
                     output logic [31:0] rv);
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_be = be; bus_wdata = wd; bus_addr = ad;
    step(rv);
  endtask

  task automatic hw(input logic [6:0] m, input logic te_s, input logic te_c,
                    input logic tc_s, input logic [7:0] d);
    logic [31:0] dummy;
    @(negedge clk);
    rx_valid = m[6]; rx_evt_set = m[5:0]; rx_data = d;
    tx_empty_set = te_s; tx_empty_clr = te_c; tx_done_set = tc_s;
    step(dummy);
  endtask

  task automatic st(output logic [15:0] sv);
    logic [31:0] rv;
    acc(1'b1, 1'b0, 4'b1100, 32'h0, BASE, rv);
    sv = rv[31:16];
  endtask

  task automatic dread();
    logic [31:0] rv;
    acc(1'b1, 1'b0, 4'b0001, 32'h0, BASE, rv);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(P*150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    st(s);
    chk("R1 reset status", {16'h0, s}, 32'h0180);
    acc(1'b1, 1'b0, 4'b0011, 32'h0, BASE, r);
    chk("R1 reset data", r, 32'h0);

    // R9 / R2 / R11: sweep every receive flag combination through a 32-bit read
    for (int m = 0; m < 128; m++) begin
      hw(7'(m), 1'b0, 1'b0, 1'b0, 8'(m ^ 8'h5A));
      if (m[6]) exp_d = 8'(m ^ 8'h5A);
      acc(1'b1, 1'b0, 4'hF, 32'h0, BASE, r);
      chk("R9 R2 R11 combined word", r, {16'h0180 | 16'(m), 8'h00, exp_d});
      st(s);
      chk("R9 receive flags cleared, bits 8/7 kept", {16'h0, s}, 32'h0180);
    end

    // R3 / R6 / R10 per flag and per status lane
    for (int i = 0; i < 7; i++) begin
      for (int ln = 0; ln < 2; ln++) begin
        hw(7'(1 << i), 1'b0, 1'b0, 1'b0, exp_d);
        dread();
        st(s);
        chk("R3 unarmed data read keeps flag", {16'h0, s}, 32'h0180 | (32'h1 << i));
        hw(7'(1 << i), 1'b0, 1'b0, 1'b0, exp_d);
        if (ln == 0) begin
          acc(1'b1, 1'b0, 4'b1000, 32'h0, BASE, r);
          chk("R6 R2 upper lane only", r, 32'h0100_0000);
        end else begin
          acc(1'b1, 1'b0, 4'b0100, 32'h0, BASE, r);
          chk("R6 R2 lower lane only", r, {8'h00, 8'h80 | 8'(1 << i), 16'h0});
        end
        dread();
        st(s);
        chk("R6 R3 lane read armed and cleared", {16'h0, s}, 32'h0180);
      end
    end

    // R7: flag set after arming survives
    for (int i = 0; i < 7; i++) begin
      int j;
      j = (i + 1) % 7;
      hw(7'(1 << i), 1'b0, 1'b0, 1'b0, exp_d);
      st(s);
      hw(7'(1 << j), 1'b0, 1'b0, 1'b0, exp_d);
      dread();
      st(s);
      chk("R7 late flag survives", {16'h0, s}, 32'h0180 | (32'h1 << j));
      dread();
      st(s);
      chk("R7 fresh pair clears", {16'h0, s}, 32'h0180);
    end

    // R10: set pulse in the same cycle as the clearing read
    for (int i = 0; i < 7; i++) begin
      hw(7'(1 << i), 1'b0, 1'b0, 1'b0, exp_d);
      st(s);
      @(negedge clk);
      bus_rd = 1'b1; bus_be = 4'b0001;
      rx_valid = (i == 6); rx_evt_set = 6'((1 << i) & 6'h3F); rx_data = exp_d;
      step(r);
      dread();
      st(s);
      chk("R10 set wins and stays unarmed", {16'h0, s}, 32'h0180 | (32'h1 << i));
      dread();
      st(s);
      chk("R10 later pair clears", {16'h0, s}, 32'h0180);
    end

    // R11 explicit data read
    hw(7'h40, 1'b0, 1'b0, 1'b0, 8'h3C);
    acc(1'b1, 1'b0, 4'b0011, 32'h0, BASE, r);
    chk("R11 data byte", r, 32'h0000_003C);
    st(s); dread();

    // R4 / R12
    st(s);
    dread();
    st(s);
    chk("R4 data read keeps TC", {16'h0, s}, 32'h0180);
    acc(1'b0, 1'b1, 4'b0001, 32'h0000_00A5, BASE, r);
    chk("R12 strobe", {31'h0, tx_valid}, 32'h1);
    chk("R12 byte", {24'h0, tx_data}, 32'hA5);
    st(s);
    chk("R4 armed write clears TC", {16'h0, s}, 32'h0100);
    chk("R12 strobe lasts one cycle", {31'h0, tx_valid}, 32'h0);
    hw(7'h00, 1'b0, 1'b0, 1'b1, exp_d);
    st(s);
    acc(1'b0, 1'b1, 4'b0010, 32'h0000_5A00, BASE, r);
    chk("R12 upper-lane write gives no strobe", {31'h0, tx_valid}, 32'h0);
    st(s);
    chk("R12 upper-lane write keeps TC", {16'h0, s}, 32'h0180);
    hw(7'h08, 1'b0, 1'b0, 1'b0, exp_d);
    st(s);
    acc(1'b0, 1'b1, 4'b0001, 32'h0000_0011, BASE, r);
    st(s);
    chk("R4 write leaves receive flag", {16'h0, s}, 32'h0108);
    dread();
    st(s);
    chk("R4 read then clears receive flag", {16'h0, s}, 32'h0100);
    hw(7'h00, 1'b0, 1'b0, 1'b1, exp_d);

    // R5 transmit-empty
    st(s);
    acc(1'b0, 1'b1, 4'b0001, 32'h0, BASE, r);
    dread();
    acc(1'b1, 1'b0, 4'hF, 32'h0, BASE, r);
    st(s);
    chk("R5 bus never clears TDRE", {16'h0, s}, 32'h0100);
    hw(7'h00, 1'b0, 1'b1, 1'b0, exp_d);
    st(s);
    chk("R5 hardware clear", {16'h0, s}, 32'h0000);
    hw(7'h00, 1'b1, 1'b1, 1'b0, exp_d);
    st(s);
    chk("R5 set beats clear", {16'h0, s}, 32'h0100);
    hw(7'h00, 1'b0, 1'b0, 1'b1, exp_d);

    // R8 status writes
    hw(7'h7F, 1'b0, 1'b0, 1'b0, 8'h77);
    exp_d = 8'h77;
    st(s);
    acc(1'b0, 1'b1, 4'b1100, 32'h0, BASE, r);
    st(s);
    chk("R8 zero write to status ignored", {16'h0, s}, 32'h01FF);
    dread();
    st(s);
    chk("R8 flags cleared only by sequence", {16'h0, s}, 32'h0180);
    hw(7'h04, 1'b0, 1'b0, 1'b0, exp_d);
    acc(1'b0, 1'b1, 4'b1100, 32'h0, BASE, r);
    dread();
    st(s);
    chk("R8 status write does not arm", {16'h0, s}, 32'h0184);
    dread();

    // R13 address mismatch
    hw(7'h02, 1'b0, 1'b0, 1'b0, exp_d);
    st(s);
    acc(1'b1, 1'b0, 4'hF, 32'h0, BASE ^ 4'h1, r);
    chk("R13 other address reads zero", r, 32'h0);
    acc(1'b0, 1'b1, 4'h1, 32'h0000_0033, BASE ^ 4'h1, r);
    chk("R13 other address no strobe", {31'h0, tx_valid}, 32'h0);
    st(s);
    chk("R13 other address no clear", {16'h0, s}, 32'h0182);
    dread();
    st(s);
    chk("R13 base pair clears", {16'h0, s}, 32'h0180);

    finish_run();
  end
endmodule